// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block chooses the power source for a battery-backed memory. It picks either the main supply or the backup battery. It also write-protects that memory while the main supply is low. Its inputs are digitized supply readings, given as integer millivolt codes: the main supply, the battery and an auxiliary monitored voltage. A strobe marks each valid set of codes. The block registers its decisions on each strobe and holds them between strobes.

The source decision uses a hysteresis band that sits evenly around the battery code, so a slowly sagging main supply cannot make the select output chatter. The chip-enable path from the memory decoder to the memory is passed through only while the main supply is above the power-fail threshold; otherwise the memory is deselected. A low-voltage detector on the auxiliary input gives an early warning of power loss. It also has its own hysteresis, and it reports only while the main supply is above the battery.

Top module: `batt_switchover`

## Requirements
- R1: After reset and before the first strobe: on_batt=1, ce_out_n=1, pfail_n=0, tdet_n=1.
- R2: Codes are taken only in a cycle with smp_vld=1. The registered outputs change at that clock edge. Without a strobe they hold, whatever the codes do.
- R3: While on_batt=0, a sample with main_mv + 10 <= batt_mv sets on_batt=1. Otherwise on_batt stays 0.
- R4: While on_batt=1, a sample with main_mv >= batt_mv + 10 clears on_batt to 0. Otherwise on_batt stays 1. Between these two bounds the selection holds (a 20 mV band).
- R5: pfail_n is 1 exactly when the last sample had main_mv > 4500, and 0 otherwise (4500 itself gives 0).
- R6: ce_out_n equals ce_in_n, combinationally, while pfail_n=1. While pfail_n=0, ce_out_n is forced to 1.
- R7: The auxiliary detector flags a low voltage when a sample has aux_mv < 1300. It clears the flag when aux_mv >= 1310. From 1300 to 1309 the flag holds. The flag is 0 after reset.
- R8: tdet_n=0 exactly when the detector flag is set and the last sample had main_mv > batt_mv. In all other cases tdet_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample-valid strobe for the three codes |
| main_mv | input | 13 | Main supply code, mV |
| batt_mv | input | 13 | Battery code, mV |
| aux_mv | input | 13 | Auxiliary monitored voltage code, mV |
| ce_in_n | input | 1 | Active-low chip enable from the decoder |
| on_batt | output | 1 | 1 = memory runs from battery, 0 = from main supply |
| ce_out_n | output | 1 | Gated active-low chip enable to the memory |
| pfail_n | output | 1 | Active-low power-fail flag |
| tdet_n | output | 1 | Active-low auxiliary low-voltage output |

## Verification
A wrong source-select or hysteresis state shows on on_batt at the clock edge of the next strobe, as a switch at the wrong code or a missing switch inside the band. A wrong power-fail state shows on pfail_n and, at once, on ce_out_n, which lets the decoder's enable through or blocks it when it should not. A detector flag that was held or cleared wrongly shows on tdet_n only while the main supply is above the battery. For that reason, codes that dwell near both 1300 and 1310 are sampled with the main supply kept high.

// File: rtl/batt_switchover.sv
module batt_switchover #(
  parameter int VW         = 13,
  parameter int SW_BAND_MV = 10,
  parameter int PF_MV      = 4500,
  parameter int TD_MV      = 1300,
  parameter int TD_HYST_MV = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [VW-1:0] main_mv,
  input  logic [VW-1:0] batt_mv,
  input  logic [VW-1:0] aux_mv,
  input  logic          ce_in_n,
  output logic          on_batt,
  output logic          ce_out_n,
  output logic          pfail_n,
  output logic          tdet_n
);
  localparam int CW = VW + 1;
  localparam logic [CW-1:0] BAND   = CW'(SW_BAND_MV);
  localparam logic [CW-1:0] PF_LIM = CW'(PF_MV);
  localparam logic [CW-1:0] TD_LO  = CW'(TD_MV);
  localparam logic [CW-1:0] TD_HI  = CW'(TD_MV + TD_HYST_MV);

  logic [CW-1:0] main_x, batt_x, aux_x;
  logic sel_batt_q, main_ok_q, above_batt_q, aux_low_q;

  assign main_x = {1'b0, main_mv};
  assign batt_x = {1'b0, batt_mv};
  assign aux_x  = {1'b0, aux_mv};

  wire go_batt = (main_x + BAND) <= batt_x;
  wire go_main = main_x >= (batt_x + BAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_batt_q   <= 1'b1;
      main_ok_q    <= 1'b0;
      above_batt_q <= 1'b0;
      aux_low_q    <= 1'b0;
    end else if (smp_vld) begin
      sel_batt_q   <= sel_batt_q ? !go_main : go_batt;
      main_ok_q    <= main_x > PF_LIM;
      above_batt_q <= main_x > batt_x;
      if (aux_x < TD_LO)       aux_low_q <= 1'b1;
      else if (aux_x >= TD_HI) aux_low_q <= 1'b0;
    end
  end

  assign on_batt  = sel_batt_q;
  assign pfail_n  = main_ok_q;
  assign ce_out_n = ce_in_n | ~main_ok_q;
  assign tdet_n   = ~(aux_low_q & above_batt_q);
endmodule

// File: rtl/batt_switchover_chk.sv
module batt_switchover_chk #(
  parameter int VW         = 13,
  parameter int SW_BAND_MV = 10,
  parameter int PF_MV      = 4500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [VW-1:0] main_mv,
  input logic [VW-1:0] batt_mv,
  input logic          on_batt,
  input logic          ce_out_n,
  input logic          pfail_n,
  input logic          tdet_n
);
  assert_hold_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(on_batt) && $stable(pfail_n) && $stable(tdet_n));

  assert_to_batt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_batt) |-> (int'($past(main_mv)) + SW_BAND_MV <= int'($past(batt_mv))));

  assert_to_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on_batt) |-> (int'($past(main_mv)) >= int'($past(batt_mv)) + SW_BAND_MV));

  assert_pf_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfail_n) |-> (int'($past(main_mv)) > PF_MV));

  assert_ce_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pfail_n |-> ce_out_n);

  assert_td_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdet_n) |-> $past(smp_vld));
endmodule

bind batt_switchover batt_switchover_chk #(
  .VW(VW), .SW_BAND_MV(SW_BAND_MV), .PF_MV(PF_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .main_mv(main_mv),
  .batt_mv(batt_mv), .on_batt(on_batt), .ce_out_n(ce_out_n),
  .pfail_n(pfail_n), .tdet_n(tdet_n)
);

// File: tb/batt_switchover_test.sv
`timescale 1ns/1ps
module batt_switchover_test;
  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, ce_in_n = 1'b1;
  logic [12:0] main_mv = '0, batt_mv = '0, aux_mv = '0;
  logic on_batt, ce_out_n, pfail_n, tdet_n;
  int n_chk = 0, n_fail = 0;
  bit m_batt = 1'b1, m_ok = 1'b0, m_gt = 1'b0, m_low = 1'b0;

  always #2 clk = ~clk;

  batt_switchover uut (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .main_mv(main_mv), .batt_mv(batt_mv), .aux_mv(aux_mv), .ce_in_n(ce_in_n),
    .on_batt(on_batt), .ce_out_n(ce_out_n), .pfail_n(pfail_n), .tdet_n(tdet_n));

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit nxt_batt(bit cur, int m, int b);
    if (cur) return !(m >= b + 10);
    return (m + 10 <= b);
  endfunction

  function automatic bit nxt_low(bit cur, int a);
    if (a < 1300) return 1'b1;
    if (a >= 1310) return 1'b0;
    return cur;
  endfunction

  task automatic check_all();
    chk("R3/R4 on_batt", on_batt, m_batt);
    chk("R5 pfail_n", pfail_n, m_ok);
    chk("R8 tdet_n", tdet_n, !(m_low && m_gt));
    chk("R6 ce_out_n", ce_out_n, ce_in_n | !m_ok);
  endtask

  task automatic sample(input int m, input int b, input int a, input logic ce);
    @(negedge clk);
    main_mv = 13'(m); batt_mv = 13'(b); aux_mv = 13'(a); ce_in_n = ce;
    smp_vld = 1'b1;
    m_batt = nxt_batt(m_batt, m, b);
    m_ok   = (m > 4500);
    m_gt   = (m > b);
    m_low  = nxt_low(m_low, a);
    @(negedge clk);
    smp_vld = 1'b0;
    check_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 on_batt", on_batt, 1'b1);
    chk("R1 ce_out_n", ce_out_n, 1'b1);
    chk("R1 pfail_n", pfail_n, 1'b0);
    chk("R1 tdet_n", tdet_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk); ce_in_n = 1'b0; #1;
    chk("R1 ce blocked before first sample", ce_out_n, 1'b1);

    // R4 band edges on rising main
    sample(3005, 3000, 1400, 1'b0); chk("R4 hold in band", on_batt, 1'b1);
    sample(3009, 3000, 1400, 1'b0); chk("R4 9 above holds", on_batt, 1'b1);
    sample(3010, 3000, 1400, 1'b0); chk("R4 10 above switches", on_batt, 1'b0);
    // R3 band edges on falling main
    sample(2991, 3000, 1400, 1'b0); chk("R3 9 below holds", on_batt, 1'b0);
    sample(2990, 3000, 1400, 1'b0); chk("R3 10 below switches", on_batt, 1'b1);
    // R5 threshold edge
    sample(4500, 3000, 1400, 1'b0); chk("R5 at 4500 low", pfail_n, 1'b0);
    sample(4501, 3000, 1400, 1'b0); chk("R5 at 4501 high", pfail_n, 1'b1);
    // R6 combinational follow
    ce_in_n = 1'b1; #1; chk("R6 follow high", ce_out_n, 1'b1);
    ce_in_n = 1'b0; #1; chk("R6 follow low", ce_out_n, 1'b0);
    // R7 detector hysteresis with main above battery
    sample(5000, 3000, 1300, 1'b0); chk("R7 at 1300 not set", tdet_n, 1'b1);
    sample(5000, 3000, 1299, 1'b0); chk("R7 1299 sets", tdet_n, 1'b0);
    sample(5000, 3000, 1309, 1'b0); chk("R7 1309 holds", tdet_n, 1'b0);
    sample(5000, 3000, 1310, 1'b0); chk("R7 1310 clears", tdet_n, 1'b1);
    // R8 detector off when main not above battery
    sample(3000, 3000, 1200, 1'b0); chk("R8 off at equal", tdet_n, 1'b1);
    sample(3001, 3000, 1200, 1'b0); chk("R8 on above", tdet_n, 0);
    // R2 no strobe: codes change, outputs hold
    @(negedge clk);
    main_mv = 13'd2000; batt_mv = 13'd3500; aux_mv = 13'd1500;
    repeat (4) @(negedge clk);
    check_all();
    chk("R2 on_batt held", on_batt, m_batt);

    // random mix near the thresholds
    for (int i = 0; i < 3000; i++) begin
      int b = 2600 + int'($urandom_range(800));
      int m, a;
      case ($urandom_range(3))
        0: m = b - 20 + int'($urandom_range(40));
        1: m = 4480 + int'($urandom_range(40));
        default: m = 2500 + int'($urandom_range(3000));
      endcase
      a = 1290 + int'($urandom_range(30));
      if ($urandom_range(4) == 0) begin
        @(negedge clk);
        main_mv = 13'($urandom_range(5500)); aux_mv = 13'($urandom_range(2000));
        ce_in_n = 1'($urandom_range(1));
        @(negedge clk);
        check_all();
      end
      sample(m, b, a, 1'($urandom_range(1)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule